// File: doc/BRIEF.md
# Quadrant-Ring Mains Notch Filter

This block takes a stream of multichannel conversion results and removes the interference that the power mains puts on them. Every result carries a channel tag and a valid strobe. The upstream converter schedules its results so that each channel is sampled once in every quarter of a mains cycle. The block keeps the most recent four quarter-cycle samples of every channel in a ring of registers, four quadrant slots for each of eight channels. For each incoming result it emits the sum of that channel's four slots, with the slot of the current quadrant replaced by the new value. Two samples half a mains period apart carry equal and opposite interference, so that component cancels in the sum. The DC content appears at four times its size, because the sum is not divided.

A quadrant pointer chooses which slot a result writes. The pointer steps forward once a result for the last channel has been stored, and it wraps from the last quadrant back to the first. A new value therefore overwrites the sample taken exactly one mains cycle earlier. Once four full scans are stored, the output is valid and refreshes with every quarter-cycle result.

A bypass input turns the filter off. Results then pass straight through, sign-extended, and the ring is left untouched. A small controller with three states tracks the fill status:
- FILL: filling after reset or after bypass is released.
- RUN: the ring is full.
- PASS: bypass is active.

The transitions are:
- reset → FILL.
- FILL → RUN on the last-channel write in the last quadrant.
- FILL or RUN → PASS when bypass is raised.
- PASS → FILL when bypass is lowered.

Top module: `lnr_notch`

## Requirements
- R1: After reset, out_valid and filled are 0 and every ring slot holds 0. While the ring is still filling, the first result for a channel therefore comes out equal to its own value.
- R2: out_valid is the in_valid of the previous cycle. out_chan is the in_chan of the previous cycle.
- R3: With bypass low, out_data is the signed sum, DW+2 bits wide and not divided, of the four quadrant slots of in_chan, where the slot of the current quadrant takes the new in_data. The sum never overflows, including when all four slots hold the most positive or the most negative input value.
- R4: The quadrant pointer is 0 after reset and steps by one after a bypass-low result for channel 7 is stored, wrapping from 3 to 0. The fifth result of a channel therefore replaces the first.
- R5: filled rises in the cycle after the fourth channel-7 result, counted with bypass low since reset or since bypass was released. Until then filled stays low.
- R6: With bypass high, out_data is in_data sign-extended to DW+2 bits, and no ring slot is written.
- R7: Raising bypass clears filled in the following cycle and sets the quadrant pointer to 0. After release, four new scans are needed before filled rises again.
- R8: A channel whose four quadrant samples are dc+a, dc+b, dc−a and dc−b gives out_data = 4·dc.
- R9: Once filled is high, every bypass-low result produces a fresh output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input result strobe |
| in_chan | input | 3 | Channel tag of the input result |
| in_data | input | 16 | Signed input result |
| bypass | input | 1 | 1 = pass results through; 0 = filter |
| out_valid | output | 1 | Output result strobe |
| out_chan | output | 3 | Channel tag of the output result |
| out_data | output | 18 | Signed quadrant sum, or the sign-extended input in bypass |
| filled | output | 1 | All four quadrants hold fresh samples |

## Verification
A directed fill uses quadrature patterns that carry a DC offset. Only a correctly cancelling sum returns four times the DC value. A wrong slot choice or a wrong pointer step leaves a residue of the interference.

A fifth scan with new values tells replacement of the oldest slot apart from replacement of any other slot. Interleaved bypass episodes show whether the ring was touched and whether the fill status restarts.

Full-scale positive and negative fills expose overflow of the sum. A seeded random mix of channel orders, gaps and data then compares every output against a bench model of the ring.

// File: rtl/lnr_pkg.sv
package lnr_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_RUN  = 2'd1,
        ST_PASS = 2'd2
    } lnr_state_e;
endpackage

// File: rtl/lnr_ring.sv
module lnr_ring #(
    parameter int DW  = 16,
    parameter int NCH = 8,
    parameter int NQ  = 4,
    localparam int CW = $clog2(NCH),
    localparam int QW = $clog2(NQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [QW-1:0]          wr_quad,
    input  logic [CW-1:0]          wr_chan,
    input  logic [DW-1:0]          wr_data,
    input  logic [CW-1:0]          rd_chan,
    output logic [NQ-1:0][DW-1:0]  rd_slots
);
    logic [DW-1:0] cells [NQ][NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                for (int c = 0; c < NCH; c++) begin
                    cells[q][c] <= '0;
                end
            end
        end else if (wr_en) begin
            cells[wr_quad][wr_chan] <= wr_data;
        end
    end

    // one read mux per quadrant slot
    for (genvar q = 0; q < NQ; q++) begin : g_rd
        assign rd_slots[q] = cells[q][rd_chan];
    end
endmodule

// File: rtl/lnr_sum.sv
module lnr_sum #(
    parameter int DW = 16,
    parameter int NQ = 4,
    localparam int QW = $clog2(NQ),
    localparam int SW = DW + QW
) (
    input  logic [NQ-1:0][DW-1:0] terms,
    output logic [SW-1:0]         total
);
    always_comb begin
        total = '0;
        for (int q = 0; q < NQ; q++) begin
            total = total + SW'($signed(terms[q]));
        end
    end
endmodule

// File: rtl/lnr_ctrl.sv
module lnr_ctrl
    import lnr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int NQ  = 4,
    localparam int CW = $clog2(NCH),
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_chan,
    input  logic          bypass,
    output logic [QW-1:0] qptr,
    output logic          filled
);
    lnr_state_e state_q, state_d;
    logic       scan_end;

    assign scan_end = in_valid && !bypass && (in_chan == CW'(NCH - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (bypass)                                  state_d = ST_PASS;
                else if (scan_end && qptr == QW'(NQ - 1))    state_d = ST_RUN;
            end
            ST_RUN:  if (bypass)  state_d = ST_PASS;
            ST_PASS: if (!bypass) state_d = ST_FILL;
            default: state_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // quadrant pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         qptr <= '0;
        else if (bypass)    qptr <= '0;
        else if (scan_end)  qptr <= (qptr == QW'(NQ - 1)) ? '0 : qptr + 1'b1;
    end

    // outputs from state
    always_comb begin
        filled = (state_q == ST_RUN);
    end
endmodule

// File: rtl/lnr_notch.sv
module lnr_notch #(
    parameter int DW  = 16,
    parameter int NCH = 8,
    parameter int NQ  = 4,
    localparam int CW = $clog2(NCH),
    localparam int QW = $clog2(NQ),
    localparam int SW = DW + QW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_chan,
    input  logic [DW-1:0] in_data,
    input  logic          bypass,
    output logic          out_valid,
    output logic [CW-1:0] out_chan,
    output logic [SW-1:0] out_data,
    output logic          filled
);
    logic [QW-1:0]         qptr;
    logic [NQ-1:0][DW-1:0] slots;
    logic [NQ-1:0][DW-1:0] terms;
    logic [SW-1:0]         total;
    logic                  wr_en;

    assign wr_en = in_valid && !bypass;

    lnr_ctrl #(.NCH(NCH), .NQ(NQ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .bypass(bypass), .qptr(qptr), .filled(filled)
    );

    lnr_ring #(.DW(DW), .NCH(NCH), .NQ(NQ)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_quad(qptr),
        .wr_chan(in_chan), .wr_data(in_data), .rd_chan(in_chan),
        .rd_slots(slots)
    );

    // the current quadrant takes the incoming sample
    for (genvar q = 0; q < NQ; q++) begin : g_term
        assign terms[q] = (qptr == QW'(q)) ? in_data : slots[q];
    end

    lnr_sum #(.DW(DW), .NQ(NQ)) u_sum (.terms(terms), .total(total));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_data <= bypass ? SW'($signed(in_data)) : total;
            end
        end
    end
endmodule

// File: rtl/lnr_notch_chk.sv
module lnr_notch_chk #(
    parameter int DW  = 16,
    parameter int NCH = 8,
    parameter int NQ  = 4,
    localparam int CW = $clog2(NCH),
    localparam int QW = $clog2(NQ),
    localparam int SW = DW + QW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [CW-1:0] in_chan,
    input logic [DW-1:0] in_data,
    input logic          bypass,
    input logic          out_valid,
    input logic [CW-1:0] out_chan,
    input logic [SW-1:0] out_data,
    input logic          filled
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) out_valid == $past(in_valid)); // R2
    AST_CHAN_TAG: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_chan == $past(in_chan)); // R2
    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && bypass) |=> out_data == {{(SW-DW){$past(in_data[DW-1])}}, $past(in_data)}); // R6
    AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) bypass |=> !filled); // R7
    AST_FILL_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(filled) |-> $past(in_valid && !bypass && in_chan == CW'(NCH - 1))); // R5
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (filled && !bypass) |=> filled); // R9
endmodule

bind lnr_notch lnr_notch_chk #(.DW(DW), .NCH(NCH), .NQ(NQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .bypass(bypass), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data), .filled(filled)
);

// File: tb/tb_lnr_notch.sv
module tb_lnr_notch;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int SW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_chan = '0;
    logic [DW-1:0] in_data = '0;
    logic          bypass = 1'b0;
    logic          out_valid;
    logic [2:0]    out_chan;
    logic [SW-1:0] out_data;
    logic          filled;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model of the ring
    int mm [4][8];
    int mq;
    bit mfill;
    bit mpass;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnr_notch dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .bypass(bypass), .out_valid(out_valid),
        .out_chan(out_chan), .out_data(out_data), .filled(filled)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sx(input int d);
        return int'($signed(DW'(d)));
    endfunction

    // entered at a falling edge; returns at the next falling edge
    task automatic step(input bit v, input int ch, input int d, input bit b,
                        input string dtag, input string ftag);
        int exp;
        in_valid = v; in_chan = 3'(ch); in_data = DW'(d); bypass = b;
        exp = 0;
        if (b) begin
            exp = sx(d);
            if (!mpass) begin mq = 0; mfill = 0; end
            mpass = 1;
        end else begin
            mpass = 0;
            if (v) begin
                for (int q = 0; q < 4; q++) exp += (q == mq) ? sx(d) : mm[q][ch];
                mm[mq][ch] = sx(d);
                if (ch == 7) begin
                    if (mq == 3) mfill = 1;
                    mq = (mq + 1) % 4;
                end
            end
        end
        @(negedge clk);
        chk(out_valid == v, "R2 valid", int'(out_valid), int'(v));
        if (v) begin
            chk(int'(out_chan) == ch, "R2 chan", int'(out_chan), ch);
            chk(int'($signed(out_data)) == exp, dtag, int'($signed(out_data)), exp);
        end
        chk(filled == mfill, ftag, int'(filled), int'(mfill));
    endtask

    task automatic scan(input int base, input string dtag, input string ftag);
        for (int c = 0; c < 8; c++) step(1, c, base + c * 37, 0, dtag, ftag);
    endtask

    task automatic flat(input int val, input string dtag);
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 8; c++) step(1, c, val, 0, dtag, "R5 flat");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1a7));
        for (int q = 0; q < 4; q++) for (int c = 0; c < 8; c++) mm[q][c] = 0;
        mq = 0; mfill = 0; mpass = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1 reset valid", int'(out_valid), 0);
        chk(filled == 0, "R1 reset filled", int'(filled), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // quadrature fill: dc+a, dc+b, dc-a, dc-b per channel
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                int dc = 100 * c - 300;
                int a  = 1000 + 50 * c;
                int b  = -700 + 90 * c;
                int v  = (s == 0) ? dc + a : (s == 1) ? dc + b : (s == 2) ? dc - a : dc - b;
                step(1, c, v, 0, (s == 0) ? "R1 first sum" : (s == 3) ? "R8 cancel" : "R3 sum", "R5 fill");
            end
        end
        chk(filled == 1, "R5 filled after four scans", int'(filled), 1);

        // fifth scan replaces quadrant 0
        scan(5000, "R4 replace oldest", "R9 stay filled");
        scan(-2000, "R9 update", "R9 stay filled");
        step(0, 0, 0, 0, "R2 idle", "R9 idle");

        // bypass episode
        step(0, 0, 0, 1, "R6 idle", "R7 bypass clears");
        for (int c = 0; c < 8; c++) step(1, 7 - c, -12345 + c * 999, 1, "R6 passthrough", "R7 bypass low");
        step(0, 0, 0, 0, "R7 idle", "R7 release");
        scan(11, "R6 ring untouched", "R7 refill");
        scan(22, "R4 pointer", "R7 refill");
        scan(33, "R4 pointer", "R7 refill");
        scan(44, "R3 sum", "R7 refill");
        chk(filled == 1, "R7 refilled", int'(filled), 1);

        // full-scale sums
        flat(32767, "R3 max positive");
        flat(-32768, "R3 max negative");

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom % 10) < 8;
            bit b = ($urandom % 100) < 3;
            int ch = (($urandom % 4) == 0) ? int'($urandom % 8) : (i % 8);
            int d = int'($urandom % 65536) - 32768;
            step(v, ch, d, b, b ? "R6 random" : "R3 random", "R5 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule